// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator with CPU Latch

This block gathers level-type interrupt lines from peripherals into one CPU interrupt request. Seven lines enter a secondary stage, where each has a flag bit and an enable bit. The OR of the enabled flags forms a secondary summary. That summary takes one slot in a six-bit primary vector. The other five slots of that vector are fed directly by device lines.

Whenever the primary vector changes while the emulation mode bit is set, the block copies the vector into a device-line field and sets a sticky CPU latch. The latch drives the interrupt request. Software releases it only by writing the clear bit of the control register while the latch is set. Software also reads and writes the secondary flag register, the secondary enable register and the primary control register through a small synchronous register port. Read data is registered.

Top module: `irqagg_top`

## Requirements
- R1: After synchronous reset, the flags, enables, control state, device-line field, `cpu_irq` and `rdata` are all zero.
- R2: A secondary flag bit takes the new level of its source line on every change of that line. A write to the flag register (select 0) clears each flag bit in 6:0 that is written as 1.
- R3: If a source line changes in the same cycle as a flag-register write that clears the same bit, the source level wins.
- R4: Bit 7 of the flag register read is the OR over bits 6:0 of (flag AND enable).
- R5: A write to the enable register (select 1) works by bit 7 of the write data. With bit 7 = 1 it sets each enable bit written as 1. With bit 7 = 0 it clears each enable bit written as 1. Bit 7 of the enable register reads as 0.
- R6: The primary vector is made as follows. Bit 0 is `dev_lines[0]` (the peripheral controller). Bit 1 is the secondary summary. Bits 5:2 are `dev_lines[4:1]`. The SCSI source enters at secondary bit 3 and the floppy source at secondary bit 5. A secondary line change therefore reaches `cpu_irq` two clock edges later, and a direct line change reaches it one edge later.
- R7: While the mode bit is set, any change of the primary vector, rising or falling, loads the vector into the device-line field and sets the CPU latch. `cpu_irq` follows the latch.
- R8: While the mode bit is clear, primary vector changes leave the field and the latch unchanged.
- R9: A control write (select 2) with bit 7 = 1 clears the latch when the latch is set. If a primary event occurs in the same cycle, the event wins and the latch stays set.
- R10: Control bit 6 (mode) is set by writing 1 and is never cleared by a write. Written bits 5:0 are ignored.
- R11: A control read returns {latch, mode, field[5:0]}.
- R12: `rdata` shows the register chosen by `reg_sel` one clock edge after the select is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_lines | input | 7 | Level interrupt lines into the secondary stage |
| dev_lines | input | 5 | Direct device lines into primary bits 0,2,3,4,5 |
| reg_sel | input | 2 | Register select: 0 flag, 1 enable, 2 control |
| reg_wr | input | 1 | Write strobe for the selected register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data of the selected register |
| cpu_irq | output | 1 | CPU interrupt request (latch state) |

## Verification
The enable register is driven with a sequence of set-mode and clear-mode writes whose masks overlap. This shows whether bit 7 selects the right polarity and whether bits that are not written keep their value. The interrupt path is driven three ways:
- A rising direct line, to check the one-edge path.
- A rising secondary line that is enabled, to check the two-edge path.
- A secondary line that is not enabled, to check that flag and summary stay separate.

A flag cleared by software while its line stays high produces a falling summary event. This must also set the latch. The remaining corner cases are the collisions between writes and source events in the same cycle:
- a flag clear against a source change;
- a latch clear against a primary event.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int SEL_W = 2;
  typedef enum logic [SEL_W-1:0] {
    SEL_FLAG = 2'd0,
    SEL_ENAB = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irqagg_sec.sv
module irqagg_sec #(
  parameter int SEC_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEC_W-1:0] src_lines,
  input  logic             flag_wr,
  input  logic             enab_wr,
  input  logic [SEC_W:0]   wdata,
  output logic [SEC_W-1:0] flags,
  output logic [SEC_W-1:0] enables,
  output logic             summary
);
  logic [SEC_W-1:0] src_q;
  logic [SEC_W-1:0] src_chg;
  logic [SEC_W-1:0] flags_nx;
  logic [SEC_W-1:0] wmask;

  assign wmask   = wdata[SEC_W-1:0];
  assign src_chg = src_lines ^ src_q;

  // a source change overrides a software clear in the same cycle
  always_comb begin
    flags_nx = flags;
    if (flag_wr) flags_nx = flags_nx & ~wmask;
    flags_nx = (flags_nx & ~src_chg) | (src_lines & src_chg);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q   <= '0;
      flags   <= '0;
      enables <= '0;
    end else begin
      src_q <= src_lines;
      flags <= flags_nx;
      if (enab_wr) begin
        if (wdata[SEC_W]) enables <= enables | wmask;
        else              enables <= enables & ~wmask;
      end
    end
  end

  assign summary = |(flags & enables);
endmodule

// File: rtl/irqagg_pri.sv
module irqagg_pri #(
  parameter int PRI_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRI_W-1:0] lines,
  input  logic             ctrl_wr,
  input  logic [PRI_W+1:0] wdata,
  output logic [PRI_W-1:0] field,
  output logic             mode,
  output logic             latch,
  output logic             evt
);
  localparam int CLR_BIT  = PRI_W + 1;
  localparam int MODE_BIT = PRI_W;

  logic [PRI_W-1:0] lines_q;

  assign evt = (lines != lines_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      lines_q <= '0;
      field   <= '0;
      mode    <= 1'b0;
      latch   <= 1'b0;
    end else begin
      lines_q <= lines;
      if (ctrl_wr && wdata[MODE_BIT]) mode <= 1'b1;
      if (mode && evt) begin
        field <= lines;
        latch <= 1'b1;
      end else if (ctrl_wr && wdata[CLR_BIT] && latch) begin
        latch <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top #(
  parameter int DATA_W   = 8,
  parameter int SEC_SLOT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-2:0] sec_lines,
  input  logic [DATA_W-4:0] dev_lines,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              cpu_irq
);
  import irqagg_pkg::*;

  localparam int SEC_W = DATA_W - 1;
  localparam int PRI_W = DATA_W - 2;

  reg_sel_e         sel;
  logic [SEC_W-1:0] sec_flags;
  logic [SEC_W-1:0] sec_en;
  logic             sec_sum;
  logic [PRI_W-1:0] pri_vec;
  logic [PRI_W-1:0] pri_field;
  logic             pri_mode;
  logic             pri_latch;
  logic             pri_evt;

  assign sel = reg_sel_e'(reg_sel);

  irqagg_sec #(.SEC_W(SEC_W)) u_sec (
    .clk       (clk),
    .rst       (rst),
    .src_lines (sec_lines),
    .flag_wr   (reg_wr && sel == SEL_FLAG),
    .enab_wr   (reg_wr && sel == SEL_ENAB),
    .wdata     (wdata),
    .flags     (sec_flags),
    .enables   (sec_en),
    .summary   (sec_sum)
  );

  // place the secondary summary at SEC_SLOT, direct lines around it
  for (genvar i = 0; i < PRI_W; i++) begin : g_vec
    if (i < SEC_SLOT) begin : g_lo
      assign pri_vec[i] = dev_lines[i];
    end else if (i == SEC_SLOT) begin : g_sum
      assign pri_vec[i] = sec_sum;
    end else begin : g_hi
      assign pri_vec[i] = dev_lines[i-1];
    end
  end

  irqagg_pri #(.PRI_W(PRI_W)) u_pri (
    .clk     (clk),
    .rst     (rst),
    .lines   (pri_vec),
    .ctrl_wr (reg_wr && sel == SEL_CTRL),
    .wdata   (wdata),
    .field   (pri_field),
    .mode    (pri_mode),
    .latch   (pri_latch),
    .evt     (pri_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (sel)
        SEL_FLAG: rdata <= {sec_sum, sec_flags};
        SEL_ENAB: rdata <= {1'b0, sec_en};
        SEL_CTRL: rdata <= {pri_latch, pri_mode, pri_field};
        default:  rdata <= '0;
      endcase
    end
  end

  assign cpu_irq = pri_latch;
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        reg_sel,
  input logic              reg_wr,
  input logic [DATA_W-1:0] wdata,
  input logic              cpu_irq,
  input logic              mode,
  input logic              pri_evt,
  input logic [DATA_W-2:0] enables
);
  logic clr_wr;
  logic en_wr;
  assign clr_wr = reg_wr && reg_sel == 2'd2 && wdata[DATA_W-1];
  assign en_wr  = reg_wr && reg_sel == 2'd1;

  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (rst)
    mode |=> mode); // R10
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    cpu_irq && !clr_wr |=> cpu_irq); // R9
  AST_LATCH_RELEASE: assert property (@(posedge clk) disable iff (rst)
    cpu_irq && clr_wr && !(mode && pri_evt) |=> !cpu_irq); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !cpu_irq && !(mode && pri_evt) |=> !cpu_irq); // R7
  AST_EN_SET: assert property (@(posedge clk) disable iff (rst)
    en_wr && wdata[DATA_W-1] |=>
      ((enables & $past(wdata[DATA_W-2:0])) == $past(wdata[DATA_W-2:0]))); // R5
  AST_EN_CLR: assert property (@(posedge clk) disable iff (rst)
    en_wr && !wdata[DATA_W-1] |=>
      ((enables & $past(wdata[DATA_W-2:0])) == '0)); // R5
endmodule

bind irqagg_top irqagg_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .reg_sel (reg_sel),
  .reg_wr  (reg_wr),
  .wdata   (wdata),
  .cpu_irq (cpu_irq),
  .mode    (pri_mode),
  .pri_evt (pri_evt),
  .enables (sec_en)
);

// File: tb/test_irqagg_top.sv
module test_irqagg_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] sec_lines = '0;
  logic [4:0] dev_lines = '0;
  logic [1:0] reg_sel = 2'd3;
  logic       reg_wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       cpu_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [1:0] A_FLAG = 2'd0, A_ENAB = 2'd1, A_CTRL = 2'd2;
  // {write data, expected enable read}
  localparam logic [15:0] EN_VEC [0:6] = '{
    16'h8505, 16'h8A0F, 16'h030C, 16'hF07C, 16'h7F00, 16'hFF7F, 16'h007F
  };

  always #4 clk = ~clk;

  irqagg_top i_irqagg_top (
    .clk(clk), .rst(rst), .sec_lines(sec_lines), .dev_lines(dev_lines),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .wdata(wdata), .rdata(rdata),
    .cpu_irq(cpu_irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_sel = a; wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_sel = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    idle(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", {7'd0, cpu_irq}, 8'h00);
    rd(A_FLAG, v); chk("R1 flag", v, 8'h00);
    rd(A_ENAB, v); chk("R1 enab", v, 8'h00);
    rd(A_CTRL, v); chk("R1 ctrl", v, 8'h00);

    // R5 enable set/clear table
    for (int k = 0; k < 7; k++) begin
      wr(A_ENAB, EN_VEC[k][15:8]);
      rd(A_ENAB, v);
      chk("R5 enab", v, EN_VEC[k][7:0]);
    end

    // R8 mode clear: events ignored
    dev_lines[0] = 1'b1; idle(2);
    chk("R8 irq", {7'd0, cpu_irq}, 8'h00);
    rd(A_CTRL, v); chk("R8 ctrl", v, 8'h00);
    dev_lines[0] = 1'b0; idle(2);

    // R10 mode set, sticky, low bits ignored
    wr(A_CTRL, 8'h40); rd(A_CTRL, v); chk("R10 set", v, 8'h40);
    wr(A_CTRL, 8'h3F); rd(A_CTRL, v); chk("R10 sticky", v, 8'h40);

    // R7/R11 direct line: one edge
    dev_lines[0] = 1'b1; idle(1);
    chk("R7 irq", {7'd0, cpu_irq}, 8'h01);
    rd(A_CTRL, v); chk("R11 ctrl", v, 8'hC1);

    // R9 clear while latched, then while not latched
    wr(A_CTRL, 8'h80);
    chk("R9 release", {7'd0, cpu_irq}, 8'h00);
    rd(A_CTRL, v); chk("R9 ctrl", v, 8'h41);
    wr(A_CTRL, 8'h80);
    rd(A_CTRL, v); chk("R9 idle clr", v, 8'h41);

    // R6 secondary path: two edges
    wr(A_ENAB, 8'h7F); wr(A_ENAB, 8'h88);
    sec_lines[3] = 1'b1; idle(1);
    chk("R6 stage1", {7'd0, cpu_irq}, 8'h00);
    idle(1);
    chk("R6 stage2", {7'd0, cpu_irq}, 8'h01);
    rd(A_FLAG, v); chk("R2 flag", v, 8'h88);
    rd(A_CTRL, v); chk("R6 ctrl", v, 8'hC3);

    // R4 disabled flag does not reach summary
    wr(A_CTRL, 8'h80);
    sec_lines[5] = 1'b1; idle(2);
    chk("R4 irq", {7'd0, cpu_irq}, 8'h00);
    rd(A_FLAG, v); chk("R4 flag", v, 8'hA8);
    rd(A_CTRL, v); chk("R4 ctrl", v, 8'h43);

    // R2 software clear; falling summary also latches (R7)
    wr(A_FLAG, 8'h08); idle(1);
    chk("R7 fall irq", {7'd0, cpu_irq}, 8'h01);
    rd(A_FLAG, v); chk("R2 clear", v, 8'h20);
    rd(A_CTRL, v); chk("R7 fall ctrl", v, 8'hC1);

    // R3 source change beats clear in same cycle
    sec_lines[6] = 1'b1;
    wr(A_FLAG, 8'h40);
    rd(A_FLAG, v); chk("R3 flag", v, 8'h60);

    // R9 event beats clear in same cycle
    wr(A_ENAB, 8'hC0);
    wr(A_CTRL, 8'h80);
    chk("R9 evt wins", {7'd0, cpu_irq}, 8'h01);
    rd(A_CTRL, v); chk("R9 ctrl", v, 8'hC3);
    wr(A_CTRL, 8'h80);
    rd(A_CTRL, v); chk("R9 final", v, 8'h43);

    // R12 read latency
    reg_sel = A_FLAG; #1;
    chk("R12 old", rdata, 8'h43);
    @(negedge clk);
    chk("R12 new", rdata, 8'hE0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule